// File: doc/BRIEF.md
# Pad Function and GPIO Register Bank

This block holds the per-pad configuration of a group of I/O pads behind a simple 32-bit register port. For every pad it keeps a two-bit function select, a two-bit drive strength code, a pull enable bit, an output data bit and an output enable bit. It also exposes the synchronized level of each pad input through read-only words. The per-pad output value and output enable reach the pad only when the pad's function select holds the GPIO code. In every other case the pad sees a tied-off alternate-function source of zero. Pull and drive settings reach the pad whatever the function.

Every writable word can be reached through four addresses. The base address replaces the whole word. The other three let software set, clear or invert chosen bits in one write, so no read-modify-write sequence is needed.

Addressing uses the word address `req_addr` (byte address bits 11:2). Byte address bits 11:8 select the group: 1 function select, 2 drive, 3 pull, 4 output data, 5 output enable, 6 input level. Bits 7:4 select the word within the group, so words of a group sit 0x10 bytes apart. Bits 3:2 select the operation: 0 write, 1 set (OR), 2 clear (AND with the inverse), 3 toggle (XOR). A read at any of the four addresses returns the word.

Top module: `padmux_gpio_bank`

## Requirements
- R1: After reset every function select word reads 0xFFFFFFFF, which is GPIO for all pads. Drive, pull, output data and output enable words read 0, and all pad_out and pad_oe bits are 0.
- R2: A read request accepted at a rising edge gives rsp_valid high for exactly the following cycle, with rsp_rdata holding the word. Cycles with no read request, including write cycles, leave rsp_valid low.
- R3: A write to a word's base address replaces the word with req_wdata, and the new value is visible from the next cycle.
- R4: A write to the set address ORs req_wdata into the word.
- R5: A write to the clear address clears every bit that is 1 in req_wdata and leaves the other bits unchanged.
- R6: A write to the toggle address XORs req_wdata into the word.
- R7: The function select of pad p is at bits 2(p mod 16)+1:2(p mod 16) of word p/16. When that code is 3, pad_out[p] and pad_oe[p] follow the output data and output enable bits. Any other code forces both to 0. Pad outputs change only after a write.
- R8: The drive code of pad p is at bits 4(p mod 8)+1:4(p mod 8) of drive word p/8, and it appears on pad_drive[2p+1:2p]. The upper two bits of each four-bit slot are discarded on write and read as 0.
- R9: The pull enable, output data and output enable of pad p are at bit p mod 32 of word p/32. pad_pull[p] follows the pull bit whatever the function select.
- R10: Input level word k bit j reports pad_in[32k+j] through a two-flop synchronizer. A level applied before rising edge n is returned by a read accepted at edge n+2 or later. Writes to these words have no effect.
- R11: Addresses with an unused group code, or with a word index beyond the group's word count, read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 10 | Word address (byte address bits 11:2) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | NUM_PADS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PADS | Pad output value |
| pad_oe | output | NUM_PADS | Pad output enable |
| pad_pull | output | NUM_PADS | Pad pull enable |
| pad_drive | output | 2*NUM_PADS | Pad drive strength code, two bits per pad |

## Verification
A read's data is due on the cycle after the edge that accepts the request. The bench drives each request on a falling edge, records the expected word in a queue, and a monitor compares it on the next falling edge when rsp_valid is seen. Register writes reach pad_out, pad_oe, pad_pull and pad_drive one edge after the write is accepted, so those ports are sampled on the falling edge that ends the write. Pad input changes are read back at exactly the second edge after the first edge that samples them, which is the earliest edge the two-flop path allows.

// File: rtl/padmux_gpio_bank.sv
module padmux_gpio_bank #(
  parameter int NUM_PADS = 96
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [11:2]           req_addr,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_rdata,
  input  logic [NUM_PADS-1:0]   pad_in,
  output logic [NUM_PADS-1:0]   pad_out,
  output logic [NUM_PADS-1:0]   pad_oe,
  output logic [NUM_PADS-1:0]   pad_pull,
  output logic [2*NUM_PADS-1:0] pad_drive
);
  localparam int FSEL_WORDS = (NUM_PADS + 15) / 16;
  localparam int DRV_WORDS  = (NUM_PADS + 7) / 8;
  localparam int BIT_WORDS  = (NUM_PADS + 31) / 32;
  localparam logic [3:0] G_FSEL = 4'd1, G_DRV = 4'd2, G_PULL = 4'd3,
                         G_DOUT = 4'd4, G_OE  = 4'd5, G_DIN  = 4'd6;
  localparam logic [1:0] OP_WR = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2;
  localparam logic [1:0] FUNC_GPIO = 2'b11;
  localparam logic       ALT_SRC = 1'b0;

  logic [FSEL_WORDS*32-1:0] fsel_q;
  logic [DRV_WORDS*16-1:0]  drv_q;
  logic [BIT_WORDS*32-1:0]  pull_q, dout_q, oe_q, din_w;
  logic [NUM_PADS-1:0]      sync1_q, sync2_q;
  logic [31:0]              rd_word;

  wire       wr   = req_valid & req_write;
  wire       rd   = req_valid & ~req_write;
  wire [3:0] grp  = req_addr[11:8];
  wire [3:0] widx = req_addr[7:4];
  wire [1:0] op   = req_addr[3:2];

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] wd,
                                        input logic [1:0] o);
    case (o)
      OP_WR:   merge = wd;
      OP_SET:  merge = old | wd;
      OP_CLR:  merge = old & ~wd;
      default: merge = old ^ wd;
    endcase
  endfunction

  function automatic logic [31:0] drv_expand(input logic [15:0] d);
    for (int i = 0; i < 8; i++) drv_expand[4*i +: 4] = {2'b00, d[2*i +: 2]};
  endfunction

  function automatic logic [15:0] drv_pack(input logic [31:0] w);
    for (int i = 0; i < 8; i++) drv_pack[2*i +: 2] = w[4*i +: 2];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= '1;
      drv_q  <= '0;
      pull_q <= '0;
      dout_q <= '0;
      oe_q   <= '0;
    end else if (wr) begin
      case (grp)
        G_FSEL:
          for (int w = 0; w < FSEL_WORDS; w++)
            if (widx == 4'(w)) fsel_q[w*32 +: 32] <= merge(fsel_q[w*32 +: 32], req_wdata, op);
        G_DRV:
          for (int w = 0; w < DRV_WORDS; w++)
            if (widx == 4'(w))
              drv_q[w*16 +: 16] <= drv_pack(merge(drv_expand(drv_q[w*16 +: 16]), req_wdata, op));
        G_PULL:
          for (int w = 0; w < BIT_WORDS; w++)
            if (widx == 4'(w)) pull_q[w*32 +: 32] <= merge(pull_q[w*32 +: 32], req_wdata, op);
        G_DOUT:
          for (int w = 0; w < BIT_WORDS; w++)
            if (widx == 4'(w)) dout_q[w*32 +: 32] <= merge(dout_q[w*32 +: 32], req_wdata, op);
        G_OE:
          for (int w = 0; w < BIT_WORDS; w++)
            if (widx == 4'(w)) oe_q[w*32 +: 32] <= merge(oe_q[w*32 +: 32], req_wdata, op);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    din_w = '0;
    din_w[NUM_PADS-1:0] = sync2_q;
  end

  always_comb begin
    rd_word = '0;
    case (grp)
      G_FSEL:
        for (int w = 0; w < FSEL_WORDS; w++) if (widx == 4'(w)) rd_word = fsel_q[w*32 +: 32];
      G_DRV:
        for (int w = 0; w < DRV_WORDS; w++) if (widx == 4'(w)) rd_word = drv_expand(drv_q[w*16 +: 16]);
      G_PULL:
        for (int w = 0; w < BIT_WORDS; w++) if (widx == 4'(w)) rd_word = pull_q[w*32 +: 32];
      G_DOUT:
        for (int w = 0; w < BIT_WORDS; w++) if (widx == 4'(w)) rd_word = dout_q[w*32 +: 32];
      G_OE:
        for (int w = 0; w < BIT_WORDS; w++) if (widx == 4'(w)) rd_word = oe_q[w*32 +: 32];
      G_DIN:
        for (int w = 0; w < BIT_WORDS; w++) if (widx == 4'(w)) rd_word = din_w[w*32 +: 32];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_word;
    end
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    wire is_gpio = (fsel_q[2*p +: 2] == FUNC_GPIO);
    assign pad_out[p] = is_gpio ? dout_q[p] : ALT_SRC;
    assign pad_oe[p]  = is_gpio ? oe_q[p]   : ALT_SRC;
  end

  assign pad_pull  = pull_q[NUM_PADS-1:0];
  assign pad_drive = drv_q[2*NUM_PADS-1:0];

  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  // R4
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && grp == G_DOUT && op == OP_SET && int'(widx) < BIT_WORDS) |=>
    ((dout_q[int'($past(widx))*32 +: 32] & $past(req_wdata)) == $past(req_wdata)));
  // R5
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && grp == G_OE && op == OP_CLR && int'(widx) < BIT_WORDS) |=>
    ((oe_q[int'($past(widx))*32 +: 32] & $past(req_wdata)) == 32'h0));
  // R8
  drv_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && grp == G_DRV) |=> ((rsp_rdata & 32'hCCCC_CCCC) == 32'h0));
  // R7
  pad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(pad_out) && $stable(pad_oe)));
  // R10
  din_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> (sync2_q == $past(pad_in, 2)));
endmodule

// File: tb/padmux_gpio_bank_tb.sv
module padmux_gpio_bank_tb_top;
  localparam int NP = 96;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:2] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe, pad_pull;
  logic [2*NP-1:0] pad_drive;
  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [95:0] pin_pat;

  always #2 clk = ~clk;

  padmux_gpio_bank #(.NUM_PADS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull(pad_pull), .pad_drive(pad_drive));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a[11:2]; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a[11:2];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R2 unexpected response", rsp_rdata, 32'hx);
      else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    check("R1 pad_oe", 32'(pad_oe != 0), 0);
    check("R1 pad_out", 32'(pad_out != 0), 0);
    bus_rd(12'h100, 32'hFFFF_FFFF, "R1 fsel w0");
    bus_rd(12'h150, 32'hFFFF_FFFF, "R1 fsel w5");
    bus_rd(12'h400, 0, "R1 dout w0");
    bus_rd(12'h520, 0, "R1 oe w2");
    bus_rd(12'h2B0, 0, "R1 drv w11");
    bus_rd(12'h310, 0, "R1 pull w1");
    // R3 base write
    bus_wr(12'h400, 32'hA5A5_0F0F);
    check("R2 no response on write", 32'(rsp_valid), 0);
    check("R7 pad_out follows dout", pad_out[31:0], 32'hA5A5_0F0F);
    bus_rd(12'h400, 32'hA5A5_0F0F, "R3 base write");
    // R4 set
    bus_wr(12'h404, 32'h0000_F000);
    bus_rd(12'h408, 32'hA5A5_FF0F, "R4 set alias");
    // R5 clear
    bus_wr(12'h408, 32'hA500_0000);
    bus_rd(12'h40C, 32'h00A5_FF0F, "R5 clear alias");
    // R6 toggle
    bus_wr(12'h40C, 32'hFFFF_0000);
    bus_rd(12'h400, 32'hFF5A_FF0F, "R6 toggle alias");
    check("R6 pad_out", pad_out[31:0], 32'hFF5A_FF0F);
    // R9 one bit per pad, word p/32
    bus_wr(12'h510, 32'h8000_0001);
    check("R9 pad_oe[32]", 32'(pad_oe[32]), 1);
    check("R9 pad_oe[63]", 32'(pad_oe[63]), 1);
    check("R9 pad_oe[31]", 32'(pad_oe[31]), 0);
    bus_wr(12'h414, 32'h0000_0001);
    check("R9 pad_out[32]", 32'(pad_out[32]), 1);
    // R7 function select gating, pad 32 is word 2 bits 1:0
    bus_wr(12'h128, 32'h0000_0003);
    check("R7 oe gated", 32'(pad_oe[32]), 0);
    check("R7 out gated", 32'(pad_out[32]), 0);
    check("R7 neighbour kept", 32'(pad_oe[63]), 1);
    bus_rd(12'h120, 32'hFFFF_FFFC, "R7 fsel readback");
    bus_wr(12'h124, 32'h0000_0002);
    check("R7 code 2 gated", 32'(pad_oe[32]), 0);
    bus_wr(12'h124, 32'h0000_0001);
    check("R7 code 3 restores oe", 32'(pad_oe[32]), 1);
    check("R7 code 3 restores out", 32'(pad_out[32]), 1);
    // R8 drive packing
    bus_wr(12'h210, 32'hFFFF_FFF1);
    bus_rd(12'h210, 32'h3333_3331, "R8 upper bits dropped");
    check("R8 pad 8 drive", 32'(pad_drive[16 +: 2]), 1);
    check("R8 pad 15 drive", 32'(pad_drive[30 +: 2]), 3);
    check("R8 pad 7 drive", 32'(pad_drive[14 +: 2]), 0);
    bus_wr(12'h2BC, 32'h0000_0002);
    check("R8 pad 88 toggle", 32'(pad_drive[176 +: 2]), 2);
    // R9 pull independent of function
    bus_wr(12'h324, 32'h8000_0000);
    check("R9 pad_pull[95]", 32'(pad_pull[95]), 1);
    bus_wr(12'h158, 32'hC000_0000);
    check("R9 pull kept when not GPIO", 32'(pad_pull[95]), 1);
    check("R9 other pulls zero", 32'(pad_pull[94:0] != 0), 0);
    // R10 synchronized inputs, read accepted at second edge after first sampling edge
    @(negedge clk);
    pin_pat = {32'hDEAD_BEEF, 32'h1234_5678, 32'h0F0F_F0F0};
    pad_in = pin_pat;
    @(negedge clk);
    bus_rd(12'h600, 32'h0F0F_F0F0, "R10 din w0");
    bus_rd(12'h610, 32'h1234_5678, "R10 din w1");
    bus_rd(12'h620, 32'hDEAD_BEEF, "R10 din w2");
    bus_wr(12'h600, 32'h0000_0000);
    bus_rd(12'h600, 32'h0F0F_F0F0, "R10 write ignored");
    pad_in = ~pin_pat;
    @(negedge clk);
    bus_rd(12'h624, 32'h2152_4110, "R10 din change");
    // R11 unmapped
    bus_rd(12'h700, 0, "R11 unused group");
    bus_rd(12'h160, 0, "R11 fsel beyond range");
    bus_wr(12'h430, 32'hFFFF_FFFF);
    bus_rd(12'h430, 0, "R11 dout beyond range");
    bus_wr(12'h004, 32'hFFFF_FFFF);
    bus_rd(12'h400, 32'hFF5A_FF0F, "R11 dout unchanged");
    check("R11 pad_out unchanged", pad_out[31:0], 32'hFF5A_FF0F);
    repeat (3) @(negedge clk);
    check("R2 all responses seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule